// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block takes the two raw open-collector lines of a PS/2 keyboard, the device clock and the device data, and turns them into one key event per keystroke. Each line is first brought into the system clock domain through a chain of synchronizer flops. It then passes a glitch filter that accepts a new level only after the level has held for a set number of system clocks.

The frame stage watches the filtered device clock. On each falling edge it takes the data bit. After eleven bits it checks three fields: the leading bit must be 0, the trailing bit must be 1, and the eight data bits together with the parity bit must hold an odd number of ones. A frame that stalls mid-way for longer than a timeout is dropped, and the stage waits for a fresh start bit.

Accepted bytes go to a decoder that absorbs the extended prefix (0xE0) and the release prefix (0xF0). Any other byte leaves the block as a single event carrying the key code, an extended flag and a released flag. A host uses the block by tying the two keyboard lines to its inputs and taking one event on each cycle where the valid output is high.

Top module: `ps2k_scan_rx`

## Requirements
- R1: While reset is high, and directly after it is released, ev_valid_o and frame_err_o are 0. No event is reported before the first complete frame.
- R2: A well-formed frame produces exactly one event within 60 system clocks of the frame's last falling device-clock edge, with ev_ext_o=0 and ev_rel_o=0. The frame is a 0 start bit, then data bits 0 to 7 (LSB first), then a parity bit that makes the data plus parity hold an odd number of ones, then a 1 stop bit. Data is sampled on falling device-clock edges, and ev_code_o equals the data byte for every byte value other than 0xE0 and 0xF0.
- R3: A byte 0xF0 produces no event by itself. The next code byte is reported with ev_rel_o=1.
- R4: A byte 0xE0 produces no event by itself. The next code byte is reported with ev_ext_o=1. The sequence 0xE0, 0xF0, code is reported as one event with both ev_ext_o=1 and ev_rel_o=1.
- R5: Each repetition of the same make code produces its own new event.
- R6: A frame with wrong parity raises frame_err_o for exactly one clock and produces no event. It also discards any pending prefix, so a code that follows 0xE0 and a bad frame is reported with ev_ext_o=0.
- R7: A frame whose start bit is 1, or whose stop bit is 0, raises frame_err_o and produces no event.
- R8: If no falling device-clock edge arrives for TIMEOUT_CYC system clocks in the middle of a frame, the partial frame is dropped with no event and no error. The next complete frame decodes correctly.
- R9: A low pulse on the device clock shorter than FILT_LEN system clocks is not counted as an edge.
- R10: Both prefix flags are cleared after every event, so a code that follows a completed extended event is reported with ev_ext_o=0 and ev_rel_o=0.
- R11: ev_valid_o is a one-cycle pulse, and ev_valid_o and frame_err_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Raw device clock line, idles high |
| ps2_data_i | input | 1 | Raw device data line, idles high |
| ev_valid_o | output | 1 | One-cycle pulse marking a key event |
| ev_code_o | output | 8 | Key code of the event |
| ev_ext_o | output | 1 | Event was preceded by the extended prefix |
| ev_rel_o | output | 1 | Event is a key release |
| frame_err_o | output | 1 | One-cycle pulse on a malformed frame |

## Verification
The bench sweeps every one of the 256 byte values through a complete frame. The two prefix values are each followed by a code byte, so that a decoder leaking a prefix as an event, or treating an ordinary code as a prefix, shows up as a wrong event count or wrong flags.

Error frames are placed directly after an extended prefix. A decoder that keeps its prefix state across an error would then mark the next key as extended. A run of identical make codes catches a decoder that suppresses repeats.

A frame abandoned half-way, followed by a long pause, would misalign every later byte if the timeout were missing. Short low spikes on the device clock would shift the bit count, and so corrupt the next frame, if the filter let them through.

// File: rtl/ps2k_pkg.sv
package ps2k_pkg;
  localparam int FRAME_BITS = 11;
  localparam logic [7:0] PFX_EXT = 8'hE0;
  localparam logic [7:0] PFX_BRK = 8'hF0;

  typedef struct packed {
    logic [7:0] code;
    logic       ext;
    logic       rel;
  } key_event_t;
endpackage

// File: rtl/ps2k_line_filter.sv
module ps2k_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   sync_w;

  assign sync_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      clean_o <= 1'b1;
    end else if (sync_w != clean_o) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        clean_o <= sync_w;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  // R9
  filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (clean_o != $past(clean_o)) |-> ($past(sync_w) == clean_o));
endmodule

// File: rtl/ps2k_frame_rx.sv
module ps2k_frame_rx
  import ps2k_pkg::*;
#(
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kclk_i,
  input  logic       kdat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       ferr_o
);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic          kclk_prev_q;
  logic [BW-1:0] bitcnt_q;
  logic [9:0]    sr_q;
  logic [TW-1:0] idle_q;
  logic          fall_w;
  logic          good_w;

  assign fall_w = kclk_prev_q & ~kclk_i;
  // sr_q[0]=start, sr_q[8:1]=data, sr_q[9]=parity; kdat_i is the stop bit
  assign good_w = ~sr_q[0] & kdat_i & (^sr_q[9:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      kclk_prev_q <= 1'b1;
      bitcnt_q    <= '0;
      sr_q        <= '0;
      idle_q      <= '0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      ferr_o      <= 1'b0;
    end else begin
      kclk_prev_q <= kclk_i;
      byte_vld_o  <= 1'b0;
      ferr_o      <= 1'b0;
      if (fall_w) begin
        idle_q <= '0;
        if (bitcnt_q == BW'(FRAME_BITS - 1)) begin
          bitcnt_q   <= '0;
          byte_vld_o <= good_w;
          ferr_o     <= ~good_w;
          byte_o     <= sr_q[8:1];
        end else begin
          bitcnt_q <= bitcnt_q + 1'b1;
          sr_q     <= {kdat_i, sr_q[9:1]};
        end
      end else if (bitcnt_q != '0) begin
        if (idle_q == TW'(TIMEOUT_CYC - 1)) begin
          idle_q   <= '0;
          bitcnt_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end else begin
        idle_q <= '0;
      end
    end
  end

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q < BW'(FRAME_BITS));
  // R8
  idle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idle_q < TW'(TIMEOUT_CYC));
  // R11
  vld_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld_o && ferr_o));
endmodule

// File: rtl/ps2k_decoder.sv
module ps2k_decoder
  import ps2k_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       ferr_i,
  output logic       ev_valid_o,
  output key_event_t ev_o,
  output logic       err_o
);
  logic ext_q;
  logic rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q      <= 1'b0;
      rel_q      <= 1'b0;
      ev_valid_o <= 1'b0;
      ev_o       <= '0;
      err_o      <= 1'b0;
    end else begin
      ev_valid_o <= 1'b0;
      err_o      <= ferr_i;
      if (ferr_i) begin
        ext_q <= 1'b0;
        rel_q <= 1'b0;
      end else if (byte_vld_i) begin
        if (byte_i == PFX_EXT) begin
          ext_q <= 1'b1;
        end else if (byte_i == PFX_BRK) begin
          rel_q <= 1'b1;
        end else begin
          ev_valid_o <= 1'b1;
          ev_o       <= '{code: byte_i, ext: ext_q, rel: rel_q};
          ext_q      <= 1'b0;
          rel_q      <= 1'b0;
        end
      end
    end
  end

  // R10
  pfx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid_o |-> (!ext_q && !rel_q));
  // R11
  ev_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid_o |=> !ev_valid_o);
  // R6
  err_no_ev_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !ev_valid_o);
  // R6
  err_clears_pfx_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!ext_q && !rel_q));
endmodule

// File: rtl/ps2k_scan_rx.sv
module ps2k_scan_rx
  import ps2k_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ev_valid_o,
  output logic [7:0] ev_code_o,
  output logic       ev_ext_o,
  output logic       ev_rel_o,
  output logic       frame_err_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_w;
  logic [NLINES-1:0] clean_w;
  logic              bvld_w;
  logic [7:0]        byte_w;
  logic              ferr_w;
  key_event_t        ev_w;

  assign raw_w = {ps2_data_i, ps2_clk_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    ps2k_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_w[i]),
      .clean_o(clean_w[i])
    );
  end

  ps2k_frame_rx #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .kclk_i    (clean_w[0]),
    .kdat_i    (clean_w[1]),
    .byte_vld_o(bvld_w),
    .byte_o    (byte_w),
    .ferr_o    (ferr_w)
  );

  ps2k_decoder u_dec (
    .clk       (clk),
    .rst       (rst),
    .byte_vld_i(bvld_w),
    .byte_i    (byte_w),
    .ferr_i    (ferr_w),
    .ev_valid_o(ev_valid_o),
    .ev_o      (ev_w),
    .err_o     (frame_err_o)
  );

  assign ev_code_o = ev_w.code;
  assign ev_ext_o  = ev_w.ext;
  assign ev_rel_o  = ev_w.rel;
endmodule

// File: tb/ps2k_scan_rx_tb.sv
module ps2k_scan_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam int GAP = 40;
  localparam int TMO = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kc = 1'b1;
  logic kd = 1'b1;
  logic ev_valid, ev_ext, ev_rel, ferr;
  logic [7:0] ev_code;

  int n_chk = 0;
  int n_bad = 0;
  int ev_cnt = 0;
  int er_cnt = 0;
  logic [7:0] last_code = '0;
  logic last_ext = 1'b0;
  logic last_rel = 1'b0;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2k_scan_rx #(.SYNC_STAGES(2), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .ps2_clk_i(kc), .ps2_data_i(kd),
    .ev_valid_o(ev_valid), .ev_code_o(ev_code), .ev_ext_o(ev_ext),
    .ev_rel_o(ev_rel), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ev_valid) begin
        ev_cnt++;
        last_code = ev_code;
        last_ext = ev_ext;
        last_rel = ev_rel;
      end
      if (ferr) er_cnt++;
      if (ev_valid && ferr) begin
        n_chk++; n_bad++;
        $display("FAIL R11 valid and error together: act=1 exp=0");
      end
      if (ev_valid && prev_valid) begin
        n_chk++; n_bad++;
        $display("FAIL R11 valid pulse longer than one cycle: act=2 exp=1");
      end
      prev_valid = ev_valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kd = b;
    wait_cyc(HALF);
    kc = 1'b0;
    wait_cyc(HALF);
    kc = 1'b1;
  endtask

  // nbits: number of bits to emit (11 for a full frame)
  task automatic send_raw(input logic [7:0] b, input bit par_flip,
                          input logic st, input logic sp, input int nbits);
    logic [10:0] f;
    f = {sp, (~^b) ^ par_flip, b, st};
    for (int i = 0; i < nbits; i++) send_bit(f[i]);
    kd = 1'b1;
    wait_cyc(GAP);
  endtask

  task automatic send(input logic [7:0] b);
    send_raw(b, 1'b0, 1'b0, 1'b1, 11);
  endtask

  task automatic expect_ev(input int ev0, input int er0, input logic [7:0] c,
                           input logic e, input logic r, input string tag);
    chk(ev_cnt == ev0 + 1, {tag, " event count"}, ev_cnt - ev0, 1);
    chk(er_cnt == er0, {tag, " error count"}, er_cnt - er0, 0);
    chk({last_code, last_ext, last_rel} == {c, e, r}, {tag, " code/ext/rel"},
        {last_code, last_ext, last_rel}, {c, e, r});
  endtask

  initial begin
    int ev0, er0;
    wait_cyc(5);
    chk(ev_valid == 1'b0 && ferr == 1'b0, "R1 outputs during reset", {ev_valid, ferr}, 0);
    rst = 1'b0;
    wait_cyc(20);
    chk(ev_valid == 1'b0 && ferr == 1'b0 && ev_cnt == 0 && er_cnt == 0,
        "R1 outputs after reset", ev_cnt + er_cnt, 0);

    // R2 R3 R4 sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      ev0 = ev_cnt; er0 = er_cnt;
      send(8'(v));
      if (v == 8'hE0) begin
        chk(ev_cnt == ev0, "R4 E0 alone gives no event", ev_cnt - ev0, 0);
        send(8'h1C);
        expect_ev(ev0, er0, 8'h1C, 1'b1, 1'b0, "R4 E0 prefix");
      end else if (v == 8'hF0) begin
        chk(ev_cnt == ev0, "R3 F0 alone gives no event", ev_cnt - ev0, 0);
        send(8'h1C);
        expect_ev(ev0, er0, 8'h1C, 1'b0, 1'b1, "R3 F0 prefix");
      end else begin
        expect_ev(ev0, er0, 8'(v), 1'b0, 1'b0, "R2 plain code");
      end
    end

    // R4 extended release
    ev0 = ev_cnt; er0 = er_cnt;
    send(8'hE0); send(8'hF0); send(8'h75);
    expect_ev(ev0, er0, 8'h75, 1'b1, 1'b1, "R4 E0 F0 release");

    // R5 repeats
    ev0 = ev_cnt;
    for (int k = 0; k < 3; k++) send(8'h1C);
    chk(ev_cnt == ev0 + 3, "R5 repeat events", ev_cnt - ev0, 3);

    // R6 parity error clears prefix
    ev0 = ev_cnt; er0 = er_cnt;
    send(8'hE0);
    send_raw(8'h2B, 1'b1, 1'b0, 1'b1, 11);
    chk(er_cnt == er0 + 1, "R6 parity error pulse", er_cnt - er0, 1);
    chk(ev_cnt == ev0, "R6 no event on parity error", ev_cnt - ev0, 0);
    er0 = er_cnt;
    send(8'h2B);
    expect_ev(ev0, er0, 8'h2B, 1'b0, 1'b0, "R6 prefix dropped");

    // R7 bad start and bad stop
    ev0 = ev_cnt; er0 = er_cnt;
    send_raw(8'h33, 1'b0, 1'b1, 1'b1, 11);
    chk(er_cnt == er0 + 1, "R7 bad start error", er_cnt - er0, 1);
    send_raw(8'h33, 1'b0, 1'b0, 1'b0, 11);
    chk(er_cnt == er0 + 2, "R7 bad stop error", er_cnt - er0, 2);
    chk(ev_cnt == ev0, "R7 no event", ev_cnt - ev0, 0);

    // R8 timeout on partial frame
    ev0 = ev_cnt; er0 = er_cnt;
    send_raw(8'h00, 1'b0, 1'b0, 1'b1, 5);
    wait_cyc(3 * TMO);
    chk(ev_cnt == ev0 && er_cnt == er0, "R8 partial frame silent", ev_cnt + er_cnt - ev0 - er0, 0);
    send(8'h2A);
    expect_ev(ev0, er0, 8'h2A, 1'b0, 1'b0, "R8 after timeout");

    // R9 short glitches on the device clock
    ev0 = ev_cnt; er0 = er_cnt;
    for (int g = 0; g < 5; g++) begin
      kc = 1'b0; wait_cyc(2); kc = 1'b1; wait_cyc(10);
    end
    wait_cyc(GAP);
    chk(ev_cnt == ev0 && er_cnt == er0, "R9 glitches ignored", ev_cnt + er_cnt - ev0 - er0, 0);
    send(8'h4D);
    expect_ev(ev0, er0, 8'h4D, 1'b0, 1'b0, "R9 frame after glitches");

    // R10 prefix cleared after event
    ev0 = ev_cnt; er0 = er_cnt;
    send(8'hE0); send(8'h74);
    expect_ev(ev0, er0, 8'h74, 1'b1, 1'b0, "R10 extended key");
    ev0 = ev_cnt;
    send(8'h74);
    expect_ev(ev0, er0, 8'h74, 1'b0, 1'b0, "R10 next key plain");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule